// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block is a small direct-mapped, write-through cache between a processor bus and a slower byte-wide main memory. Each of its 2^IDX_W entries holds one data byte and one tag. The low address bits select the entry and the upper bits form the tag. A combinational comparator raises a hit flag when the stored tag at the selected entry equals the tag bits of the request address.

A four-state controller sequences every access. A read that hits completes in a single cycle from the cache. A read that misses starts a memory read and passes the memory byte straight to the processor. While it waits for memory, it writes that byte and its tag into the entry. Every write takes one path whether or not it hits: the entry's data and tag are overwritten and the byte is written to memory. The controller waits for the memory's ready handshake before it acknowledges. Reset clears every tag and data byte to zero, so the contents start in a known state.

Top module: `wt_cache_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the controller state is idle (3'b000). In that state ack, mem_start, cache_drive and mem_drive are all 0, and mem_rw_n and cache_rw_n are both 1.
- R2: cpu_hit is 1 exactly when the stored tag at entry cpu_addr[3:0] equals cpu_addr[7:4]. Reset clears every tag and data byte to 0, so after reset a read of address 0x05 hits and returns 0x00.
- R3: In idle with neither cpu_rd nor cpu_wr asserted, the state stays idle and mem_start stays 0.
- R4: A read that hits moves to the read-hit state (3'b010) for exactly one cycle. In that cycle cpu_ack is 1, cpu_rdata carries the cached byte and mem_start is 0. The state is then idle.
- R5: A read that misses moves to the read-miss state (3'b100). There mem_start is 1, mem_rw_n is 1 (read), cpu_ack equals mem_ready and cpu_rdata carries mem_rdata. The state returns to idle after mem_ready.
- R6: A read miss fills the entry with the memory byte and the address tag, so an immediately repeated read of the same address hits and returns the same byte.
- R7: Any write, hit or miss, moves to the write state (3'b001). There mem_start is 1, mem_rw_n is 0, mem_wdata is cpu_wdata and cpu_ack equals mem_ready. After mem_ready the byte is in memory and the state is idle.
- R8: A write overwrites the data and tag of the selected entry. A later read of that address hits with the written byte, and a read of another address that maps to the same entry then misses.
- R9: When cpu_rd and cpu_wr are both asserted in idle, the write takes priority.
- R10: The write and read-miss states hold while mem_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Read request, held until ack |
| cpu_wr | input | 1 | Write request, held until ack |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte (0 when not driven) |
| cpu_ack | output | 1 | Access complete |
| cpu_hit | output | 1 | Tag match at indexed entry |
| fsm_state | output | 3 | Controller state code |
| cache_drive | output | 1 | Cache byte drives cpu_rdata |
| cache_rw_n | output | 1 | Cache array read (1) / write (0) |
| mem_drive | output | 1 | Memory byte drives cpu_rdata |
| mem_start | output | 1 | Memory access start |
| mem_rw_n | output | 1 | Memory read (1) / write (0) |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ready | input | 1 | Memory access complete |

## Verification
The state changes on the first clock edge after a request. The bench therefore raises a request on a falling edge and reads the state code on the next falling edge. At that point a hit read must already show its acknowledge and cached byte. A write or miss must show the memory strobes with acknowledge still low, since the memory model takes several cycles. For those states the bench then checks on each falling edge until the acknowledge appears, and takes the returned byte in that same half cycle. One falling edge after the request drops, it expects idle.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'b000,
        ST_WRITE = 3'b001,
        ST_RHIT  = 3'b010,
        ST_RMISS = 3'b100
    } ctl_state_e;

    typedef struct packed {
        logic ack;
        logic cache_drv;
        logic cache_rw_n;
        logic mem_drv;
        logic mem_rw_n;
        logic mem_start;
    } ctl_out_t;

endpackage

// File: rtl/wtc_store.sv
module wtc_store #(
    parameter int IDX_W  = 4,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/wtc_match.sv
module wtc_match #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    assign hit = (stored_tag == req_tag);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_rd,
    input  logic       req_wr,
    input  logic       hit,
    input  logic       mem_ready,
    output ctl_state_e state_o,
    output ctl_out_t   ctl_o
);
    typedef struct packed {
        ctl_state_e state;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_wr)             r_d.state = ST_WRITE;
                else if (req_rd && hit) r_d.state = ST_RHIT;
                else if (req_rd)        r_d.state = ST_RMISS;
            end
            ST_RHIT:  r_d.state = ST_IDLE;
            ST_WRITE: if (mem_ready) r_d.state = ST_IDLE;
            ST_RMISS: if (mem_ready) r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.state <= ST_IDLE;
        else        r_q <= r_d;
    end

    always_comb begin
        ctl_o = '{ack: 1'b0, cache_drv: 1'b0, cache_rw_n: 1'b1,
                  mem_drv: 1'b0, mem_rw_n: 1'b1, mem_start: 1'b0};
        unique case (r_q.state)
            ST_RHIT: begin
                ctl_o.ack       = 1'b1;
                ctl_o.cache_drv = 1'b1;
            end
            ST_WRITE: begin
                ctl_o.ack        = mem_ready;
                ctl_o.cache_rw_n = 1'b0;
                ctl_o.mem_rw_n   = 1'b0;
                ctl_o.mem_start  = 1'b1;
            end
            ST_RMISS: begin
                ctl_o.ack        = mem_ready;
                ctl_o.cache_rw_n = 1'b0;
                ctl_o.mem_drv    = 1'b1;
                ctl_o.mem_start  = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/wt_cache_top.sv
module wt_cache_top
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_hit,
    output logic [2:0]        fsm_state,
    output logic              cache_drive,
    output logic              cache_rw_n,
    output logic              mem_drive,
    output logic              mem_start,
    output logic              mem_rw_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  stored_tag;
    logic [DATA_W-1:0] cached_byte;
    logic [DATA_W-1:0] fill_byte;
    logic              hit;
    ctl_state_e        state;
    ctl_out_t          ctl;

    assign idx     = cpu_addr[IDX_W-1:0];
    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];

    wtc_store #(.IDX_W(IDX_W), .WIDTH(TAG_W)) tag_i (
        .clk(clk), .rst_n(rst_n), .we(!ctl.cache_rw_n),
        .idx(idx), .wdata(req_tag), .rdata(stored_tag)
    );

    assign fill_byte = (state == ST_RMISS) ? mem_rdata : cpu_wdata;

    wtc_store #(.IDX_W(IDX_W), .WIDTH(DATA_W)) data_i (
        .clk(clk), .rst_n(rst_n), .we(!ctl.cache_rw_n),
        .idx(idx), .wdata(fill_byte), .rdata(cached_byte)
    );

    wtc_match #(.TAG_W(TAG_W)) match_i (
        .stored_tag(stored_tag), .req_tag(req_tag), .hit(hit)
    );

    wtc_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_rd(cpu_rd), .req_wr(cpu_wr),
        .hit(hit), .mem_ready(mem_ready), .state_o(state), .ctl_o(ctl)
    );

    always_comb begin
        if (ctl.cache_drv)    cpu_rdata = cached_byte;
        else if (ctl.mem_drv) cpu_rdata = mem_rdata;
        else                  cpu_rdata = '0;
    end

    assign cpu_ack     = ctl.ack;
    assign cpu_hit     = hit;
    assign fsm_state   = state;
    assign cache_drive = ctl.cache_drv;
    assign cache_rw_n  = ctl.cache_rw_n;
    assign mem_drive   = ctl.mem_drv;
    assign mem_start   = ctl.mem_start;
    assign mem_rw_n    = ctl.mem_rw_n;
    assign mem_addr    = cpu_addr;
    assign mem_wdata   = cpu_wdata;

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_rd,
    input logic       cpu_wr,
    input logic       cpu_ack,
    input logic       cpu_hit,
    input logic [2:0] fsm_state,
    input logic       mem_start,
    input logic       mem_rw_n,
    input logic       mem_ready
);
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fsm_state) <= 1);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'b000 && !cpu_rd && !cpu_wr) |=> fsm_state == 3'b000);

    a_r4_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'b010 |=> fsm_state == 3'b000);

    a_r5_miss_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'b100 |-> (mem_start && mem_rw_n && cpu_ack == mem_ready));

    a_r7_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == 3'b001 |-> (mem_start && !mem_rw_n && cpu_ack == mem_ready));

    a_r9_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'b000 && cpu_wr) |=> fsm_state == 3'b001);

    a_r4_hit_path: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'b000 && cpu_rd && !cpu_wr && cpu_hit) |=> fsm_state == 3'b010);

    a_r10_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_state == 3'b001 || fsm_state == 3'b100) && !mem_ready) |=> $stable(fsm_state));

endmodule

bind wt_cache_top wt_cache_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_ack(cpu_ack), .cpu_hit(cpu_hit), .fsm_state(fsm_state),
    .mem_start(mem_start), .mem_rw_n(mem_rw_n), .mem_ready(mem_ready)
);

// File: tb/wt_cache_tb.sv
module wt_cache_top_tb_top;
    localparam int MEM_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ack, cpu_hit;
    logic [2:0] fsm_state;
    logic       cache_drive, cache_rw_n, mem_drive, mem_start, mem_rw_n;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    wt_cache_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .cpu_hit(cpu_hit), .fsm_state(fsm_state),
        .cache_drive(cache_drive), .cache_rw_n(cache_rw_n), .mem_drive(mem_drive),
        .mem_start(mem_start), .mem_rw_n(mem_rw_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Behavioural slow memory
    logic [7:0] ram [256];
    logic       busy = 1'b0, rdy_q = 1'b0;
    int         cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
            busy  <= 1'b0;
            rdy_q <= 1'b0;
            cnt   <= 0;
        end else if (rdy_q) begin
            rdy_q <= 1'b0;
        end else if (busy) begin
            if (cnt == 0) begin
                rdy_q <= 1'b1;
                busy  <= 1'b0;
                if (!mem_rw_n) ram[mem_addr] <= mem_wdata;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (mem_start) begin
            busy <= 1'b1;
            cnt  <= MEM_LAT - 1;
        end
    end

    assign mem_ready = rdy_q;
    assign mem_rdata = ram[mem_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic wait_ack(input string req, input logic [2:0] st);
        int guard = 0;
        while (!cpu_ack && guard < 50) begin
            check(fsm_state == st, req, fsm_state, st);   // R10 hold
            @(negedge clk);
            guard++;
        end
        check(cpu_ack == 1'b1, req, cpu_ack, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(fsm_state == 3'b000, "R1 state in reset", fsm_state, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fsm_state == 3'b000, "R1 state after reset", fsm_state, 0);
        check({cpu_ack, mem_start, cache_drive, mem_drive} == 4'b0, "R1 strobes",
              {cpu_ack, mem_start, cache_drive, mem_drive}, 0);
        check(mem_rw_n && cache_rw_n, "R1 rw lines", {mem_rw_n, cache_rw_n}, 3);
    endtask

    task automatic test_idle();
        repeat (3) begin
            @(negedge clk);
            check(fsm_state == 3'b000 && !mem_start, "R3 idle hold", fsm_state, 0);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit also_rd);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = also_rd;
        @(negedge clk);
        check(fsm_state == 3'b001, also_rd ? "R9 write priority" : "R7 write state", fsm_state, 1);
        check(mem_start && !mem_rw_n && mem_wdata == d, "R7 write strobes",
              {mem_start, mem_rw_n, mem_wdata}, {1'b1, 1'b0, d});
        check(!cpu_ack, "R10 no early ack", cpu_ack, 0);
        wait_ack("R10 write hold", 3'b001);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        @(negedge clk);
        check(fsm_state == 3'b000, "R7 back to idle", fsm_state, 0);
        check(ram[a] == d, "R7 memory written", ram[a], d);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input bit exp_hit);
        logic [7:0] got;
        cpu_addr = a;
        #1;
        check(cpu_hit == exp_hit, "R2 hit compare", cpu_hit, exp_hit);
        cpu_rd = 1'b1;
        @(negedge clk);
        if (exp_hit) begin
            check(fsm_state == 3'b010, "R4 read-hit state", fsm_state, 2);
            check(cpu_ack && !mem_start, "R4 one-cycle ack", {cpu_ack, mem_start}, 2);
        end else begin
            check(fsm_state == 3'b100, "R5 read-miss state", fsm_state, 4);
            check(mem_start && mem_rw_n, "R5 memory read strobes", {mem_start, mem_rw_n}, 3);
            wait_ack("R5 miss wait", 3'b100);
        end
        got = cpu_rdata;
        check(got == exp, exp_hit ? "R4 hit data" : "R5 miss data", got, exp);
        cpu_rd = 1'b0;
        @(negedge clk);
        check(fsm_state == 3'b000, "R4 R5 back to idle", fsm_state, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        test_idle();
        do_read(8'h05, 8'h00, 1'b1);                 // R2 cleared tags hit
        do_write(8'h00, 8'h11, 1'b0);
        do_write(8'h10, 8'h22, 1'b0);
        do_write(8'h20, 8'h33, 1'b0);
        do_write(8'h30, 8'h44, 1'b0);                // R8 last write owns entry 0
        do_read(8'h30, 8'h44, 1'b1);                 // R8 written entry hits
        do_read(8'h20, 8'h33, 1'b0);                 // R8 conflicting address misses
        do_read(8'h20, 8'h33, 1'b1);                 // R6 refill hit
        do_read(8'h10, 8'h22, 1'b0);
        do_read(8'h10, 8'h22, 1'b1);                 // R6
        do_read(8'h00, 8'h11, 1'b0);
        do_read(8'h00, 8'h11, 1'b1);                 // R6
        do_read(8'h30, 8'h44, 1'b0);                 // R8 evicted by fill
        do_write(8'h47, 8'h5A, 1'b1);                // R9 read+write together
        do_read(8'h47, 8'h5A, 1'b1);                 // R8
        test_idle();
        finish_run();
    end

endmodule